// File: doc/BRIEF.md
# Omega-Flip Bit Permutation Network

This block reorders the bits of a word whose width is a power of two. The word passes through a chain of stages. The first group of stages are omega stages: each applies a perfect shuffle, then a column of two-by-two switches. The remaining stages are flip stages, the mirror image: a switch column, then the inverse shuffle. Every switch has its own control bit, which either passes its bit pair straight through or exchanges the two bits. The network only moves bits. A bit is never copied or lost, so the output is always a rearrangement of the input.

The network is purely combinational and has neither clock nor reset. The surrounding logic supplies one control word per stage, typically taken from a pseudo-random source. With enough stages, which is twice the base-2 logarithm of the width, every ordering of the input can be reached. This is how a parallel stochastic number generator scatters the ones of a thermometer-coded value across its output word. The number of omega stages and the number of flip stages are separate parameters.

Top module: `perm_network`

## Requirements
- R1: For every control setting, the number of ones in `dataOut` equals the number of ones in `dataIn`.
- R2: When `NUM_OMEGA` and `NUM_FLIP` both equal log2(`WIDTH`) and `ctrlIn` is all zero, `dataOut` equals `dataIn`.
- R3: An omega stage first moves the bit at index i to the index formed by rotating i one place left within log2(`WIDTH`) bits. It then applies its switch column. Stages 0 to `NUM_OMEGA`-1 are omega stages, and stage 0 is nearest `dataIn`.
- R4: A flip stage first applies its switch column. It then moves the bit at index i to the index formed by rotating i one place right. Stages `NUM_OMEGA` onward are flip stages, and the last stage drives `dataOut`.
- R5: Stage s takes its controls from `ctrlIn[s*WIDTH/2 +: WIDTH/2]`. Bit k of that slice steers the switch on positions 2k and 2k+1. A value of 0 passes the pair straight through and a value of 1 exchanges it. With `WIDTH`=8 and 3+3 stages, setting only control bit 0 of stage 0 maps input bit 0 to output bit 4.
- R6: An input with exactly one bit set gives an output with exactly one bit set, for every control setting.
- R7: An all-zero input word and an all-one input word appear unchanged at the output, whatever the control.
- R8: The behaviour of R3 to R5 holds for other parameter values. It is checked at `WIDTH`=16 with four omega and four flip stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | WIDTH | Word to be reordered |
| ctrlIn | input | (NUM_OMEGA+NUM_FLIP)*WIDTH/2 | Switch controls, one WIDTH/2 slice per stage, stage 0 in the low bits |
| dataOut | output | WIDTH | Reordered word |

## Verification
The bench sets a single control bit by hand and checks where one input bit lands. A network that rotated the shuffle the wrong way, put the switch before the shuffle in omega stages, or read the wrong control slice would send that bit somewhere other than output bit 4. Walking a lone one across all positions under random controls exposes a switch that copies or drops a bit instead of exchanging it: the population count breaks. The all-zero-control identity catches a flip stage that is not the exact inverse of an omega stage. A second, wider instance catches index arithmetic that only happens to work at eight bits.

// File: rtl/perm_pkg.sv
package perm_pkg;

  // Index rotated one place towards the MSB within idxBits bits (perfect shuffle).
  function automatic int rotlIdx(input int idx, input int idxBits);
    return ((idx << 1) | (idx >> (idxBits - 1))) & ((1 << idxBits) - 1);
  endfunction

  // Index rotated one place towards the LSB within idxBits bits (inverse shuffle).
  function automatic int rotrIdx(input int idx, input int idxBits);
    return ((idx >> 1) | ((idx & 1) << (idxBits - 1))) & ((1 << idxBits) - 1);
  endfunction

endpackage

// File: rtl/perm_switch_col.sv
module perm_switch_col #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   colIn,
  input  logic [WIDTH/2-1:0] swapCtl,
  output logic [WIDTH-1:0]   colOut
);
  localparam int HALF = WIDTH / 2;

  for (genvar k = 0; k < HALF; k++) begin : g_sw
    assign colOut[2*k]   = swapCtl[k] ? colIn[2*k+1] : colIn[2*k];
    assign colOut[2*k+1] = swapCtl[k] ? colIn[2*k]   : colIn[2*k+1];
  end
endmodule

// File: rtl/perm_stage.sv
module perm_stage #(
  parameter int WIDTH   = 8,
  parameter bit IS_FLIP = 1'b0
) (
  input  logic [WIDTH-1:0]   stageIn,
  input  logic [WIDTH/2-1:0] swapCtl,
  output logic [WIDTH-1:0]   stageOut
);
  localparam int IDX_BITS = $clog2(WIDTH);

  logic [WIDTH-1:0] colIn;
  logic [WIDTH-1:0] colOut;

  perm_switch_col #(.WIDTH(WIDTH)) u_col (
    .colIn  (colIn),
    .swapCtl(swapCtl),
    .colOut (colOut)
  );

  if (!IS_FLIP) begin : g_omega
    for (genvar i = 0; i < WIDTH; i++) begin : g_shuf
      localparam int DST = perm_pkg::rotlIdx(i, IDX_BITS);
      assign colIn[DST] = stageIn[i];
    end
    assign stageOut = colOut;
  end else begin : g_flip
    assign colIn = stageIn;
    for (genvar i = 0; i < WIDTH; i++) begin : g_unshuf
      localparam int DST = perm_pkg::rotrIdx(i, IDX_BITS);
      assign stageOut[DST] = colOut[i];
    end
  end
endmodule

// File: rtl/perm_ctrl_split.sv
module perm_ctrl_split #(
  parameter int WIDTH      = 8,
  parameter int NUM_STAGES = 6
) (
  input  logic [NUM_STAGES*(WIDTH/2)-1:0]      ctrlFlat,
  output logic [NUM_STAGES-1:0][WIDTH/2-1:0]   stageCtl
);
  localparam int HALF = WIDTH / 2;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_slice
    assign stageCtl[s] = ctrlFlat[s*HALF +: HALF];
  end
endmodule

// File: rtl/perm_datapath.sv
module perm_datapath #(
  parameter int WIDTH     = 8,
  parameter int NUM_OMEGA = 3,
  parameter int NUM_FLIP  = 3
) (
  input  logic [WIDTH-1:0]                              pathIn,
  input  logic [NUM_OMEGA+NUM_FLIP-1:0][WIDTH/2-1:0]    stageCtl,
  output logic [WIDTH-1:0]                              pathOut
);
  localparam int NUM_STAGES = NUM_OMEGA + NUM_FLIP;

  logic [NUM_STAGES:0][WIDTH-1:0] chain;

  assign chain[0] = pathIn;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    perm_stage #(
      .WIDTH  (WIDTH),
      .IS_FLIP(s >= NUM_OMEGA)
    ) u_stage (
      .stageIn (chain[s]),
      .swapCtl (stageCtl[s]),
      .stageOut(chain[s+1])
    );
  end

  assign pathOut = chain[NUM_STAGES];
endmodule

// File: rtl/perm_network.sv
module perm_network #(
  parameter int WIDTH     = 8,
  parameter int NUM_OMEGA = $clog2(WIDTH),
  parameter int NUM_FLIP  = $clog2(WIDTH),
  localparam int NUM_STAGES = NUM_OMEGA + NUM_FLIP,
  localparam int CTRL_BITS  = NUM_STAGES * (WIDTH / 2)
) (
  input  logic [WIDTH-1:0]     dataIn,
  input  logic [CTRL_BITS-1:0] ctrlIn,
  output logic [WIDTH-1:0]     dataOut
);
  logic [NUM_STAGES-1:0][WIDTH/2-1:0] stageCtl;

  perm_ctrl_split #(
    .WIDTH     (WIDTH),
    .NUM_STAGES(NUM_STAGES)
  ) u_ctrl (
    .ctrlFlat(ctrlIn),
    .stageCtl(stageCtl)
  );

  perm_datapath #(
    .WIDTH    (WIDTH),
    .NUM_OMEGA(NUM_OMEGA),
    .NUM_FLIP (NUM_FLIP)
  ) u_path (
    .pathIn  (dataIn),
    .stageCtl(stageCtl),
    .pathOut (dataOut)
  );
endmodule

// File: rtl/perm_network_chk.sv
module perm_network_chk #(
  parameter int WIDTH     = 8,
  parameter int NUM_OMEGA = 3,
  parameter int NUM_FLIP  = 3,
  localparam int CTRL_BITS = (NUM_OMEGA + NUM_FLIP) * (WIDTH / 2),
  localparam int IDX_BITS  = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0]     dataIn,
  input logic [CTRL_BITS-1:0] ctrlIn,
  input logic [WIDTH-1:0]     dataOut
);
  always_comb begin
    if (!$isunknown({dataIn, ctrlIn})) begin
      // R1: the ones are only moved, never created or lost
      a_r1_ones_kept: assert ($countones(dataOut) == $countones(dataIn));
      // R6: a lone one stays a lone one
      if ($countones(dataIn) == 1)
        a_r6_single_bit: assert ($countones(dataOut) == 1);
      // R7: uniform words are fixed points
      if (dataIn == '0)
        a_r7_all_zero: assert (dataOut == '0);
      if (dataIn == '1)
        a_r7_all_one: assert (dataOut == '1);
      // R2: full-depth network with idle switches is the identity
      if (NUM_OMEGA == IDX_BITS && NUM_FLIP == IDX_BITS && ctrlIn == '0)
        a_r2_identity: assert (dataOut == dataIn);
    end
  end
endmodule

bind perm_network perm_network_chk #(
  .WIDTH    (WIDTH),
  .NUM_OMEGA(NUM_OMEGA),
  .NUM_FLIP (NUM_FLIP)
) u_chk (
  .dataIn (dataIn),
  .ctrlIn (ctrlIn),
  .dataOut(dataOut)
);

// File: tb/sim_perm_network.sv
module sim_perm_network;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [7:0]  dIn0;
  logic [23:0] cIn0;
  logic [7:0]  dOut0;
  logic [15:0] dIn1;
  logic [63:0] cIn1;
  logic [15:0] dOut1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  perm_network #(.WIDTH(8)) u0 (.dataIn(dIn0), .ctrlIn(cIn0), .dataOut(dOut0));
  perm_network #(.WIDTH(16), .NUM_OMEGA(4), .NUM_FLIP(4)) u1 (.dataIn(dIn1), .ctrlIn(cIn1), .dataOut(dOut1));

  // Behavioural model: follow each bit through shuffle / switch / unshuffle.
  function automatic logic [15:0] refPerm(input int w, input int nOm, input int nFl,
                                          input logic [15:0] din, input logic [127:0] ctl);
    int lg = $clog2(w);
    int half = w / 2;
    logic [15:0] cur = din;
    logic [15:0] tmp;
    for (int s = 0; s < nOm + nFl; s++) begin
      tmp = '0;
      if (s < nOm) begin
        for (int i = 0; i < w; i++) tmp[((i << 1) | (i >> (lg - 1))) % w] = cur[i];
        for (int k = 0; k < half; k++)
          if (ctl[s*half + k]) begin
            logic b = tmp[2*k];
            tmp[2*k] = tmp[2*k+1];
            tmp[2*k+1] = b;
          end
      end else begin
        for (int k = 0; k < half; k++)
          if (ctl[s*half + k]) begin
            logic b = cur[2*k];
            cur[2*k] = cur[2*k+1];
            cur[2*k+1] = b;
          end
        for (int i = 0; i < w; i++) tmp[(i >> 1) | ((i & 1) << (lg - 1))] = cur[i];
      end
      cur = tmp;
    end
    return cur;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply0(input logic [7:0] d, input logic [23:0] c);
    @(negedge clk);
    dIn0 = d;
    cIn0 = c;
    #2;
  endtask

  task automatic apply1(input logic [15:0] d, input logic [63:0] c);
    @(negedge clk);
    dIn1 = d;
    cIn1 = c;
    #2;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    dIn0 = '0; cIn0 = '0; dIn1 = '0; cIn1 = '0;
    #2;
    check("R7 initial zero", {8'h0, dOut0}, 16'h0);

    // R2: identity with idle switches
    for (int n = 0; n < 8; n++) begin
      logic [7:0] d = 8'($urandom);
      apply0(d, '0);
      check("R2 identity w8", {8'h0, dOut0}, {8'h0, d});
    end
    apply1(16'hA5C3, '0);
    check("R2 identity w16", dOut1, 16'hA5C3);

    // R5: hand-traced route, stage 0 switch 0 only
    apply0(8'h01, 24'h000001);
    check("R5 single switch route", {8'h0, dOut0}, 16'h0010);

    // R6: walk a lone one under random control
    for (int b = 0; b < 8; b++) begin
      logic [23:0] c = 24'($urandom);
      logic [15:0] e;
      apply0(8'(1 << b), c);
      e = refPerm(8, 3, 3, 16'(1 << b), {104'h0, c});
      check("R6 lone one count", 16'($countones(dOut0)), 16'd1);
      check("R6 lone one position", {8'h0, dOut0}, e);
    end

    // R7: uniform words under random control
    for (int n = 0; n < 4; n++) begin
      apply0(8'hFF, 24'($urandom));
      check("R7 all ones w8", {8'h0, dOut0}, 16'h00FF);
      apply0(8'h00, 24'($urandom));
      check("R7 all zeros w8", {8'h0, dOut0}, 16'h0);
    end

    // R3 R4 R5 R1: random words and controls against the model
    for (int n = 0; n < 300; n++) begin
      logic [7:0]  d = 8'($urandom);
      logic [23:0] c = 24'($urandom);
      apply0(d, c);
      check("R3 R4 R5 w8 mapping", {8'h0, dOut0}, refPerm(8, 3, 3, {8'h0, d}, {104'h0, c}));
      check("R1 ones kept w8", 16'($countones(dOut0)), 16'($countones(d)));
    end

    // R8: wider instance
    for (int n = 0; n < 300; n++) begin
      logic [15:0] d = 16'($urandom);
      logic [63:0] c = {32'($urandom), 32'($urandom)};
      apply1(d, c);
      check("R8 w16 mapping", dOut1, refPerm(16, 4, 4, d, {64'h0, c}));
      check("R1 ones kept w16", 16'($countones(dOut1)), 16'($countones(d)));
    end
    apply1(16'hFFFF, {32'($urandom), 32'($urandom)});
    check("R7 all ones w16", dOut1, 16'hFFFF);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule